// File: doc/BRIEF.md
# Gated Auxiliary Clock Divider

This block divides an auxiliary clock by a programmable integer and presents the result as a one-cycle enable pulse, `divTick`, that downstream logic uses in place of a divided clock. It holds a single 32-bit configuration word written over a plain write-enable, address and data bus. The word holds an enable bit and a 4-bit division value `DIV`. While the divider runs, `divTick` pulses once every `DIV + 1` input cycles.

The configuration word is tied to the enable state. While the divider is off, the stored division value is frozen and cannot change. Writes that would alter it are dropped, and `divTick` stays low. A single write can switch the divider on and load a new division value together. A new division value written while the divider runs waits for the current period to finish, so no period is ever cut short. Switching the divider off clears its counter. After a restart, the first pulse therefore comes a full `DIV + 1` cycles later.

Top module: `auxDivider`

## Requirements
- R1: After reset, `cfgRd` reads 0 (divider off, DIV = 0) and `divTick` is low.
- R2: While enabled with an unchanged DIV, `divTick` is high for exactly one cycle in every DIV + 1 cycles, for each DIV from 0 to 15. With DIV = 0 it is high on every cycle.
- R3: The enable bit is bit 0 of the configuration word. DIV occupies bits 15:12. `cfgRd` shows the stored enable bit and the stored DIV in those positions.
- R4: A write whose bit 0 is 0 leaves the stored DIV unchanged. This holds whether the divider was on or off.
- R5: While the divider is off, `divTick` stays low.
- R6: A write with bit 0 = 1 to a disabled divider enables it and stores the DIV from the same write. A write with bit 0 = 0 to an enabled divider disables it and drops its DIV field.
- R7: Bits 31:16 and 11:1 of `cfgRd` always read 0, whatever was written to them.
- R8: A DIV written while the divider runs is stored at once and shown on `cfgRd`. The period already in progress still ends on the old count, and the following periods use the new value.
- R9: Disabling clears the period counter. After an enabling write at clock edge E, the first `divTick` occurs in the (DIV+1)-th cycle after E, and periods of DIV + 1 follow.
- R10: A write whose address differs from `CFG_ADDR` (default 0) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Auxiliary input clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the configuration bus |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 32 | Write data |
| cfgRd | output | 32 | Current configuration word |
| divTick | output | 1 | Divided-clock enable pulse |

## Verification
The hardest case to reach from the ports is a division change that arrives while a period is in progress. The bench must show that the old period runs to its end before the new length applies. To do this, it enables the divider with a known value and counts cycles from the enabling edge. It then writes a new value at a chosen mid-period cycle and checks every following cycle against an arithmetic schedule. A second sequence disables the divider mid-count, writes a new division value while it is off, and re-enables it. This shows that the dropped value never appears, that no residual count shortens the first period, and that every division value from 0 to 15 yields its exact period.

// File: rtl/auxDivPkg.sv
package auxDivPkg;
  localparam int REG_W   = 32;
  localparam int DIV_W   = 4;
  localparam int DIV_LSB = 12;
  localparam int EN_BIT  = 0;

  // Strobes from the register control into the counting datapath.
  typedef struct packed {
    logic             clear;    // counter forced to zero this edge
    logic             load;     // enabling write: start fresh with loadVal
    logic             running;  // divider currently enabled
    logic [DIV_W-1:0] loadVal;  // division value carried by the enabling write
    logic [DIV_W-1:0] pendVal;  // stored value adopted at the next boundary
  } divStrobes_t;
endpackage

// File: rtl/auxDivCtrl.sv
module auxDivCtrl
  import auxDivPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  cfgRd,
  output divStrobes_t       strb
);
  localparam int RSV_HI_LSB = DIV_LSB + DIV_W;

  logic             enQ;
  logic [DIV_W-1:0] divQ;
  logic             wrHit;
  logic             wrEnBit;
  logic [DIV_W-1:0] wrDiv;
  logic             enNext;
  logic             acceptDiv;

  assign wrHit     = wrEn && (wrAddr == CFG_ADDR);
  assign wrEnBit   = wrData[EN_BIT];
  assign wrDiv     = wrData[DIV_LSB +: DIV_W];
  assign enNext    = wrHit ? wrEnBit : enQ;
  // the division field is taken only when the word leaves the divider enabled
  assign acceptDiv = wrHit && wrEnBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= 1'b0;
      divQ <= '0;
    end else begin
      enQ <= enNext;
      if (acceptDiv) divQ <= wrDiv;
    end
  end

  always_comb begin
    strb.clear   = !enNext;
    strb.load    = wrHit && wrEnBit && !enQ;
    strb.running = enQ;
    strb.loadVal = wrDiv;
    strb.pendVal = divQ;
  end

  always_comb begin
    cfgRd                      = '0;
    cfgRd[EN_BIT]              = enQ;
    cfgRd[DIV_LSB +: DIV_W]    = divQ;
  end

  // R4: without an enabling write the stored value cannot move while off
  p_div_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ && !(wrHit && wrEnBit)) |=> $stable(divQ));

  // R10: a miss on the address leaves the whole word untouched
  p_addr_miss_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrHit) |=> $stable(cfgRd));

  // R7: reserved bits written as ones never show up on the read side
  p_rsv_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && ((|wrData[REG_W-1:RSV_HI_LSB]) || (|wrData[DIV_LSB-1:EN_BIT+1])))
      |=> (cfgRd[REG_W-1:RSV_HI_LSB] == '0 && cfgRd[DIV_LSB-1:EN_BIT+1] == '0));
endmodule

// File: rtl/auxDivPath.sv
module auxDivPath
  import auxDivPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  divStrobes_t strb,
  output logic        divTick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] activeDiv;
  logic             atBoundary;

  assign atBoundary = (cnt == activeDiv);
  assign divTick    = strb.running && atBoundary;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      activeDiv <= '0;
    end else if (strb.clear) begin
      cnt <= '0;
    end else if (strb.load) begin
      cnt       <= '0;
      activeDiv <= strb.loadVal;
    end else if (strb.running) begin
      if (atBoundary) begin
        cnt       <= '0;
        activeDiv <= strb.pendVal;  // new length only at a period boundary
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  // R5: no pulse while off
  p_quiet_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.running |-> !divTick);

  // R2: counter never passes the active length
  p_no_overrun_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.running |-> (cnt <= activeDiv));

  // R2: pulses are isolated whenever the next period is longer than one cycle
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    (divTick && strb.pendVal != '0 && !strb.clear) |=> !divTick);

  // R8: the active length cannot change inside a period
  p_len_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.running && !atBoundary && !strb.clear) |=> $stable(activeDiv));

  // R9: every start begins from a cleared counter
  p_fresh_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.running) |-> (cnt == '0));
endmodule

// File: rtl/auxDivider.sv
module auxDivider
  import auxDivPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  output logic [31:0]       cfgRd,
  output logic              divTick
);
  divStrobes_t strb;

  auxDivCtrl #(
    .ADDR_W  (ADDR_W),
    .CFG_ADDR(CFG_ADDR)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .cfgRd (cfgRd),
    .strb  (strb)
  );

  auxDivPath uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .divTick(divTick)
  );
endmodule

// File: tb/auxDivider_test.sv
module auxDivider_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [3:0]  wrAddr;
  logic [31:0] wrData;
  logic [31:0] cfgRd;
  logic        divTick;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  auxDivider uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cfgRd(cfgRd), .divTick(divTick)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; wrAddr = '0;
  endtask

  task automatic expectTick(input bit exp, input string tag);
    chk(divTick == exp, tag, {31'b0, divTick}, {31'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (4) @(negedge clk);
    chk(cfgRd == 32'h0, "R1 reset word", cfgRd, 32'h0);
    expectTick(1'b0, "R1 reset tick");
    rstN = 1'b1;
    @(negedge clk);

    // R4/R5: division write while off is dropped, output silent
    regWrite(4'h0, 32'h0000_7000);
    chk(cfgRd == 32'h0, "R4 div write while off", cfgRd, 32'h0);
    for (int k = 0; k < 20; k++) begin
      expectTick(1'b0, "R5 off quiet");
      @(negedge clk);
    end

    // R2/R3/R6/R9: sweep every division value from an off state
    for (int d = 0; d < 16; d++) begin
      regWrite(4'h0, (32'(d) << 12) | 32'h1);
      chk(cfgRd == ((32'(d) << 12) | 32'h1), "R3 R6 enable readback", cfgRd, (32'(d) << 12) | 32'h1);
      for (int k = 0; k < 3 * (d + 1); k++) begin
        expectTick((k % (d + 1)) == d, "R2 R9 period");
        @(negedge clk);
      end
      regWrite(4'h0, 32'h0);
      chk(cfgRd == (32'(d) << 12), "R6 disable keeps div", cfgRd, 32'(d) << 12);
      expectTick(1'b0, "R5 after disable");
    end

    // R8: DIV 3 -> 1 written in cycle 1 of a period
    regWrite(4'h0, 32'h0000_3001);
    expectTick(1'b0, "R8 cycle0");
    @(negedge clk);
    expectTick(1'b0, "R8 cycle1");
    regWrite(4'h0, 32'h0000_1001);
    chk(cfgRd == 32'h0000_1001, "R8 immediate readback", cfgRd, 32'h0000_1001);
    for (int k = 2; k < 10; k++) begin
      expectTick(k == 3 || k == 5 || k == 7 || k == 9, "R8 boundary switch");
      @(negedge clk);
    end
    regWrite(4'h0, 32'h0);

    // R9/R6: disable mid-count with a dropped DIV, then restart
    regWrite(4'h0, 32'h0000_5001);
    @(negedge clk);
    @(negedge clk);
    regWrite(4'h0, 32'h0000_9000);
    chk(cfgRd == 32'h0000_5000, "R6 disabling write drops div", cfgRd, 32'h0000_5000);
    for (int k = 0; k < 6; k++) begin
      expectTick(1'b0, "R5 off after mid-count stop");
      @(negedge clk);
    end
    regWrite(4'h0, 32'h0000_5001);
    for (int k = 0; k < 12; k++) begin
      expectTick((k % 6) == 5, "R9 restart from zero");
      @(negedge clk);
    end

    // R7: reserved ones are ignored
    regWrite(4'h0, 32'hFFFF_FFFF);
    chk(cfgRd == 32'h0000_F001, "R7 reserved read zero", cfgRd, 32'h0000_F001);

    // R10: other address has no effect on state or pulse train
    regWrite(4'h3, 32'h0000_2000);
    chk(cfgRd == 32'h0000_F001, "R10 address miss", cfgRd, 32'h0000_F001);
    regWrite(4'h0, 32'h0);
    regWrite(4'h0, 32'h0000_2001);
    regWrite(4'h7, 32'h0000_0000);
    for (int k = 1; k < 7; k++) begin
      expectTick((k % 3) == 2, "R10 pulses continue");
      @(negedge clk);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule